// File: doc/BRIEF.md
# Condition-Gated Integer Execute Unit

This block is the execute stage of a small 32-bit RISC datapath. Every cycle it accepts one operation: a 4-bit condition selector, a 2-bit opcode choosing a move, an inverted move, an addition or a subtraction, a set-flags bit, a first operand and a second operand that an upstream shifter has already shifted. The shifter's carry-out also arrives as an input.

The unit tests the condition selector against its own negative, zero, carry and overflow flags. If the test fails, nothing happens. If it passes, the unit registers the result and raises a write strobe for one cycle. When set-flags is also high, it loads new flags into the flag register. Those flags then gate the next operation.

Outputs are registered, so an operation presented before a rising edge shows its result, strobe and flags just after that edge. Fetch, immediate decode, the register file and the shifter sit outside the block.

Top module: `cond_exec_unit`

## Requirements
- R1: While rst_ni is low, res_o, wr_o and flags_o are all zero. flags_o bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V.
- R2: Condition selectors 0000 to 0111 test a single flag. Each pair passes first on the flag set, then on the flag clear, in this order: Z (0000, 0001), C (0010, 0011), N (0100, 0101), V (0110, 0111).
- R3: Selector 1000 passes when C=1 and Z=0. Selector 1001 passes when C=0 or Z=1.
- R4: Selector 1010 passes when N=V, and 1011 when N!=V. Selector 1100 passes when Z=0 and N=V, and 1101 when Z=1 or N!=V.
- R5: Selector 1110 always passes, and selector 1111 never passes, whatever the flags hold.
- R6: For an operation presented before a rising edge, wr_o after that edge is 1 exactly when its condition passed. In that case res_o carries its result. Otherwise res_o keeps its previous value.
- R7: Opcode 00 (move) writes the second operand, and opcode 01 (inverted move) writes its bitwise NOT.
- R8: Opcode 10 (add) writes first plus second operand, modulo 2^32. With set-flags it sets C to the carry-out and V to the signed overflow.
- R9: Opcode 11 (subtract) writes first minus second operand, modulo 2^32. With set-flags it sets C to 1 when no borrow occurs (first >= second, unsigned) and V to the signed overflow.
- R10: A passing operation with set-flags low leaves flags_o unchanged.
- R11: A failing operation leaves flags_o unchanged, even with set-flags high.
- R12: Every flag-setting operation sets N to result bit 31 and Z to (result==0). For move and inverted move, C takes shift_carry_i and V keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_i | input | 4 | Condition selector |
| op_i | input | 2 | Opcode: 00 move, 01 inverted move, 10 add, 11 subtract |
| set_flags_i | input | 1 | Request a flag update |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand, already shifted |
| shift_carry_i | input | 1 | Shifter carry-out |
| res_o | output | 32 | Registered result |
| wr_o | output | 1 | Result write strobe |
| flags_o | output | 4 | Flag register {N,Z,C,V} |

## Verification
A wrong flag register shows up at the ports in two ways. It appears on flags_o right after the bad edge. It also appears one operation later, as a wrong wr_o, when a condition selector tests the corrupted flag. The bench steers the flags into every combination that a result can produce, which is every combination except N and Z both set. Under each combination it sweeps all sixteen selectors, so a wrong decode term flips wr_o within one cycle. Carry, borrow and overflow corners are checked on the flags in the cycle that follows each flag-setting operation.

// File: rtl/cond_exec_pkg.sv
package cond_exec_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned COND_W = 4;

  typedef enum logic [1:0] {
    OP_MOV = 2'b00,
    OP_MVN = 2'b01,
    OP_ADD = 2'b10,
    OP_SUB = 2'b11
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/exec_cond_eval.sv
module exec_cond_eval
  import cond_exec_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  flags_t            flags_i,
  output logic              pass_o
);
  logic n_eq_v;
  assign n_eq_v = (flags_i.n == flags_i.v);

  always_comb begin
    unique case (cond_i)
      4'h0: pass_o = flags_i.z;
      4'h1: pass_o = !flags_i.z;
      4'h2: pass_o = flags_i.c;
      4'h3: pass_o = !flags_i.c;
      4'h4: pass_o = flags_i.n;
      4'h5: pass_o = !flags_i.n;
      4'h6: pass_o = flags_i.v;
      4'h7: pass_o = !flags_i.v;
      4'h8: pass_o = flags_i.c && !flags_i.z;
      4'h9: pass_o = !flags_i.c || flags_i.z;
      4'hA: pass_o = n_eq_v;
      4'hB: pass_o = !n_eq_v;
      4'hC: pass_o = !flags_i.z && n_eq_v;
      4'hD: pass_o = flags_i.z || !n_eq_v;
      4'hE: pass_o = 1'b1;
      default: pass_o = 1'b0; // 1111: never
    endcase
  end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import cond_exec_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             shift_carry_i,
  input  flags_t           flags_i,
  output logic [WIDTH-1:0] res_o,
  output flags_t           flags_o
);
  localparam int unsigned MSB = WIDTH - 1;

  op_e             op;
  logic            is_sub;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   sum;
  logic             arith_v;

  assign op     = op_e'(op_i);
  assign is_sub = (op == OP_SUB);
  // subtract as a + ~b + 1; carry-out then means no borrow
  assign b_eff  = is_sub ? ~opb_i : opb_i;
  assign sum    = {1'b0, opa_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, is_sub};
  assign arith_v = (opa_i[MSB] == b_eff[MSB]) && (sum[MSB] != opa_i[MSB]);

  always_comb begin
    unique case (op)
      OP_MOV:  res_o = opb_i;
      OP_MVN:  res_o = ~opb_i;
      default: res_o = sum[WIDTH-1:0];
    endcase
  end

  always_comb begin
    flags_o.n = res_o[MSB];
    flags_o.z = (res_o == '0);
    if (op == OP_ADD || op == OP_SUB) begin
      flags_o.c = sum[WIDTH];
      flags_o.v = arith_v;
    end else begin
      flags_o.c = shift_carry_i;
      flags_o.v = flags_i.v;
    end
  end
endmodule

// File: rtl/exec_commit.sv
module exec_commit
  import cond_exec_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pass_i,
  input  logic             set_flags_i,
  input  logic [WIDTH-1:0] res_i,
  input  flags_t           flags_i,
  output logic [WIDTH-1:0] res_o,
  output logic             wr_o,
  output flags_t           flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      wr_o    <= 1'b0;
      flags_o <= '0;
    end else begin
      wr_o <= pass_i;
      if (pass_i) res_o <= res_i;
      if (pass_i && set_flags_i) flags_o <= flags_i;
    end
  end
endmodule

// File: rtl/cond_exec_unit.sv
module cond_exec_unit
  import cond_exec_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [COND_W-1:0] cond_i,
  input  logic [1:0]        op_i,
  input  logic              set_flags_i,
  input  logic [WIDTH-1:0]  opa_i,
  input  logic [WIDTH-1:0]  opb_i,
  input  logic              shift_carry_i,
  output logic [WIDTH-1:0]  res_o,
  output logic              wr_o,
  output logic [3:0]        flags_o
);
  flags_t           flags_q;
  flags_t           flags_nxt;
  logic             pass;
  logic [WIDTH-1:0] alu_res;

  exec_cond_eval u_cond (
    .cond_i  (cond_i),
    .flags_i (flags_q),
    .pass_o  (pass)
  );

  exec_alu #(.WIDTH(WIDTH)) u_alu (
    .op_i          (op_i),
    .opa_i         (opa_i),
    .opb_i         (opb_i),
    .shift_carry_i (shift_carry_i),
    .flags_i       (flags_q),
    .res_o         (alu_res),
    .flags_o       (flags_nxt)
  );

  exec_commit #(.WIDTH(WIDTH)) u_commit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pass_i      (pass),
    .set_flags_i (set_flags_i),
    .res_i       (alu_res),
    .flags_i     (flags_nxt),
    .res_o       (res_o),
    .wr_o        (wr_o),
    .flags_o     (flags_q)
  );

  assign flags_o = flags_q;
endmodule

// File: rtl/cond_exec_unit_chk.sv
module cond_exec_unit_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       cond_i,
  input logic [1:0]       op_i,
  input logic             set_flags_i,
  input logic [WIDTH-1:0] res_o,
  input logic             wr_o,
  input logic [3:0]       flags_o
);
  // R6: no write, no change of result
  a_r6_hold_res: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_o |-> res_o == $past(res_o));

  // R11: a failed operation never touches the flags
  a_r11_fail_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_o |-> flags_o == $past(flags_o));

  // R10
  a_r10_no_s_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(set_flags_i)) |-> flags_o == $past(flags_o));

  // R5
  a_r5_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(cond_i) == 4'hE) |-> wr_o);

  a_r5_never: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cond_i) == 4'hF) |-> !wr_o);

  // R12: moves keep V
  a_r12_move_keeps_v: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(op_i[1]) && wr_o) |-> flags_o[0] == $past(flags_o[0]));
endmodule

bind cond_exec_unit cond_exec_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cond_i      (cond_i),
  .op_i        (op_i),
  .set_flags_i (set_flags_i),
  .res_o       (res_o),
  .wr_o        (wr_o),
  .flags_o     (flags_o)
);

// File: tb/cond_exec_unit_bench.sv
module cond_exec_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cond = 4'hF;
  logic [1:0]  op = 2'b00;
  logic        sf = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic        sc = 1'b0;
  logic [31:0] res;
  logic        wr;
  logic [3:0]  flg;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_exec_unit u_cond_exec_unit (
    .clk_i(clk), .rst_ni(rst_n), .cond_i(cond), .op_i(op), .set_flags_i(sf),
    .opa_i(opa), .opb_i(opb), .shift_carry_i(sc),
    .res_o(res), .wr_o(wr), .flags_o(flg)
  );

  typedef struct {
    logic        wr;
    logic [31:0] res;
    logic [3:0]  fl;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0;
  int          n_err = 0;
  logic [3:0]  mf = '0;   // model flags {N,Z,C,V}
  logic [31:0] mres = '0;
  bit          done = 0;

  function automatic bit model_pass(input logic [3:0] c, input logic [3:0] f);
    bit n, z, cc, v;
    {n, z, cc, v} = f;
    case (c)
      4'd0:  return z == 1;
      4'd1:  return z == 0;
      4'd2:  return cc == 1;
      4'd3:  return cc == 0;
      4'd4:  return n == 1;
      4'd5:  return n == 0;
      4'd6:  return v == 1;
      4'd7:  return v == 0;
      4'd8:  return cc == 1 && z == 0;
      4'd9:  return cc == 0 || z == 1;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return z == 0 && n == v;
      4'd13: return z == 1 || n != v;
      4'd14: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic issue(input logic [3:0] c, input logic [1:0] o, input logic s,
                       input logic [31:0] a, input logic [31:0] b, input logic shc,
                       input string tag);
    exp_t        e;
    bit          p;
    logic [31:0] r;
    logic [3:0]  nf;
    longint      sa, sb, sr;
    @(negedge clk);
    cond = c; op = o; sf = s; opa = a; opb = b; sc = shc;
    p  = model_pass(c, mf);
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    nf = mf;
    case (o)
      2'b00: begin r = b; nf[1] = shc; end
      2'b01: begin r = ~b; nf[1] = shc; end
      2'b10: begin
        r = a + b;
        nf[1] = ({1'b0, a} + {1'b0, b}) > 33'h0_FFFF_FFFF;
        sr = sa + sb;
        nf[0] = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      default: begin
        r = a - b;
        nf[1] = (a >= b);
        sr = sa - sb;
        nf[0] = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
    endcase
    nf[3] = r[31];
    nf[2] = (r == 32'd0);
    if (p) begin
      mres = r;
      if (s) mf = nf;
    end
    e.wr = p; e.res = mres; e.fl = mf; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    cond = 4'hF; sf = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (wr !== e.wr || res !== e.res || flg !== e.fl) begin
          n_err++;
          $display("FAIL %s: wr/res/flags actual %0b/%h/%b expected %0b/%h/%b",
                   e.tag, wr, res, flg, e.wr, e.res, e.fl);
        end
      end
    end
  end

  // brings flags to {n,z,c,v}; n&z never both set
  task automatic set_flags(input bit n, input bit z, input bit c, input bit v);
    if (v) issue(4'hE, 2'b10, 1'b1, 32'h7FFF_FFFF, 32'd1, 1'b0, "R8 setup");
    else   issue(4'hE, 2'b10, 1'b1, 32'd0, 32'd0, 1'b0, "R8 setup");
    issue(4'hE, 2'b00, 1'b1, 32'd0, z ? 32'd0 : (n ? 32'h8000_0000 : 32'd1), c, "R12 setup");
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 2);
    n_chk++;
    if (res !== '0 || wr !== 1'b0 || flg !== 4'b0) begin
      n_err++;
      $display("FAIL R1: reset res/wr/flags actual %h/%0b/%b expected 0/0/0000", res, wr, flg);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6: every selector under every reachable flag pattern
    for (int f = 0; f < 16; f++) begin
      if (f[3] && f[2]) continue;
      set_flags(f[3], f[2], f[1], f[0]);
      for (int c = 0; c < 16; c++)
        issue(4'(c), 2'b00, 1'b0, 32'd0, 32'(f * 16 + c + 100), 1'b0, "R2/R3/R4/R5 cond sweep");
    end

    // R7 moves
    issue(4'hE, 2'b00, 1'b0, 32'h1234_5678, 32'hCAFE_0001, 1'b0, "R7 move");
    issue(4'hE, 2'b01, 1'b0, 32'd0, 32'h0F0F_00FF, 1'b0, "R7 inverted move");
    // R12 flag rules for moves
    issue(4'hE, 2'b01, 1'b1, 32'd0, 32'd0, 1'b1, "R12 mvn neg, C from shifter");
    issue(4'hE, 2'b00, 1'b1, 32'd0, 32'd0, 1'b0, "R12 mov zero");
    // R8 add corners
    issue(4'hE, 2'b10, 1'b1, 32'hFFFF_FFFF, 32'd1, 1'b0, "R8 add carry wrap to zero");
    issue(4'hE, 2'b10, 1'b1, 32'h8000_0000, 32'h8000_0000, 1'b0, "R8 add neg overflow");
    issue(4'hE, 2'b10, 1'b1, 32'd20, 32'd22, 1'b0, "R8 add plain");
    // R9 sub corners
    issue(4'hE, 2'b11, 1'b1, 32'd5, 32'd5, 1'b0, "R9 sub equal");
    issue(4'hE, 2'b11, 1'b1, 32'd3, 32'd5, 1'b0, "R9 sub borrow");
    issue(4'hE, 2'b11, 1'b1, 32'h8000_0000, 32'd1, 1'b0, "R9 sub overflow");
    issue(4'hE, 2'b11, 1'b1, 32'd0, 32'd0, 1'b0, "R9 sub zero no borrow");
    // R10: no S keeps flags (Z=1 now)
    issue(4'hE, 2'b10, 1'b0, 32'h7FFF_FFFF, 32'd1, 1'b0, "R10 add without S");
    // R11: failed cond with S keeps flags and result
    issue(4'h1, 2'b10, 1'b1, 32'h7FFF_FFFF, 32'd1, 1'b0, "R11 failed NE with S");
    issue(4'hF, 2'b11, 1'b1, 32'd1, 32'd9, 1'b1, "R11 never with S");
    issue(4'h0, 2'b11, 1'b1, 32'd1, 32'd9, 1'b0, "R6 passing EQ with S");
    // back-to-back flag dependency: signed compare then GT/LT
    issue(4'hE, 2'b11, 1'b1, 32'hFFFF_FFFE, 32'd3, 1'b0, "R9 signed compare");
    issue(4'hB, 2'b00, 1'b0, 32'd0, 32'd77, 1'b0, "R4 LT after compare");
    issue(4'hC, 2'b00, 1'b0, 32'd0, 32'd88, 1'b0, "R4 GT after compare");
    issue(4'h8, 2'b00, 1'b0, 32'd0, 32'd99, 1'b0, "R3 HI after compare");
    idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule